// File: doc/BRIEF.md
# Interleaved Converter Output Multiplexer with Overrange Clamp

This block sits behind a bank of interleaved converter slices. Each slice delivers a signed correction-stage result on its own bus. A slice-select input, advanced by one slice per clock by an external phase generator, chooses which slice is finishing in the current cycle. The chosen result is saturated to an unsigned straight-binary code and an overrange flag, and registered on the rising clock edge. The result then drives a shared output bus that an active-low enable can release to high impedance.

The saturation works in three bands. A negative result gives code zero. A result inside the output range passes through unchanged. A result one LSB or more above full scale raises the overrange flag and forces every data bit to one. A data-valid strobe is registered with the word. It stays low in reset and whenever the calibration-busy input was high in the previous cycle, so the words produced during start-up calibration are marked invalid.

Top module: `conv_out_mux`

## Requirements
- R1: The word registered at a rising edge comes from the slice whose index equals `slice_sel_i` at that edge. Slice k occupies bits [k*RES_W +: RES_W] of `slice_res_i`.
- R2: A selected result r, read as RES_W-bit two's complement, with 0 <= r <= 2^DATA_W-1 appears on `dout_io` as the unsigned binary value r (bit 0 = LSB), with `ovr_io` = 0.
- R3: A selected result r >= 2^DATA_W gives `ovr_io` = 1 and all DATA_W data bits at 1.
- R4: A selected negative result gives `dout_io` = 0 and `ovr_io` = 0.
- R5: Data and overrange change only at a rising clock edge, one cycle after the inputs that produce them. Input changes between edges have no effect on the outputs.
- R6: While `oe_n_i` = 1, the block releases `dout_io` and `ovr_io`, so another driver sets the bus value. While `oe_n_i` = 0, the block drives the registered word.
- R7: `dvalid_o` is 1 after an edge only if `rst` and `cal_busy_i` were both 0 at that edge. The enable input does not affect it.
- R8: After an edge with `rst` = 1 (synchronous), the data word is 0, overrange is 0 and `dvalid_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| slice_res_i | input | N_SLICES*RES_W | Concatenated signed slice results |
| slice_sel_i | input | $clog2(N_SLICES) | Index of the slice finishing this cycle |
| cal_busy_i | input | 1 | Calibration in progress; suppresses valid |
| oe_n_i | input | 1 | Active-low output enable for data and overrange |
| dout_io | inout | DATA_W | Tri-statable straight-binary output code |
| ovr_io | inout | 1 | Tri-statable overrange flag |
| dvalid_o | output | 1 | Data-valid strobe |

## Verification
The bench builds the block with four slices, a 4-bit output code and 6-bit signed slice results. With this configuration, every one of the 64 possible result values can be sent through every slice position while the select rotates. That covers each boundary of the clamp: -1, 0, full scale, full scale plus one and the extreme values. Release of the bus is shown by a second bench driver taking over the lines while the enable is high. The start-up and calibration-busy gating of the valid strobe is also exercised.

// File: rtl/conv_out_mux_pkg.sv
package conv_out_mux_pkg;
  typedef enum logic [1:0] {
    BAND_UNDER = 2'd0,
    BAND_INSIDE = 2'd1,
    BAND_OVER = 2'd2
  } band_e;
endpackage

// File: rtl/com_slice_sel.sv
module com_slice_sel #(
  parameter int N_SLICES = 16,
  parameter int RES_W = 12,
  localparam int SEL_W = (N_SLICES > 1) ? $clog2(N_SLICES) : 1
) (
  input  logic [N_SLICES*RES_W-1:0] bus_i,
  input  logic [SEL_W-1:0]          sel_i,
  output logic [RES_W-1:0]          res_o
);
  logic [RES_W-1:0] lane [N_SLICES];

  for (genvar k = 0; k < N_SLICES; k++) begin : g_lane
    assign lane[k] = bus_i[k*RES_W +: RES_W];
  end

  always_comb begin
    res_o = '0;
    for (int k = 0; k < N_SLICES; k++) begin
      if (sel_i == SEL_W'(k)) res_o = lane[k];
    end
  end
endmodule

// File: rtl/com_range_clamp.sv
module com_range_clamp
  import conv_out_mux_pkg::*;
#(
  parameter int DATA_W = 10,
  parameter int RES_W = 12
) (
  input  logic [RES_W-1:0]  res_i,
  output logic [DATA_W-1:0] code_o,
  output logic              ovr_o,
  output band_e             band_o
);
  localparam int FULL = (1 << DATA_W) - 1;

  logic signed [RES_W-1:0] res_s;
  int res_int;

  assign res_s = $signed(res_i);
  assign res_int = int'(res_s);

  always_comb begin
    if (res_int < 0) begin
      band_o = BAND_UNDER;
      code_o = '0;
      ovr_o = 1'b0;
    end else if (res_int > FULL) begin
      band_o = BAND_OVER;
      code_o = '1;
      ovr_o = 1'b1;
    end else begin
      band_o = BAND_INSIDE;
      code_o = res_i[DATA_W-1:0];
      ovr_o = 1'b0;
    end
  end
endmodule

// File: rtl/com_out_stage.sv
module com_out_stage #(
  parameter int DATA_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] code_i,
  input  logic              ovr_i,
  input  logic              busy_i,
  output logic [DATA_W-1:0] code_q,
  output logic              ovr_q,
  output logic              valid_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      code_q <= '0;
      ovr_q <= 1'b0;
      valid_q <= 1'b0;
    end else begin
      code_q <= code_i;
      ovr_q <= ovr_i;
      valid_q <= ~busy_i;
    end
  end

  a_r3_flag_forces_ones: assert property (@(posedge clk) disable iff (rst)
    ovr_q |-> (&code_q));

  a_r7_busy_blocks_valid: assert property (@(posedge clk) disable iff (rst)
    busy_i |=> !valid_q);

  a_r8_reset_clears: assert property (@(posedge clk)
    rst |=> (code_q == '0 && !ovr_q && !valid_q));
endmodule

// File: rtl/conv_out_mux.sv
module conv_out_mux
  import conv_out_mux_pkg::*;
#(
  parameter int N_SLICES = 16,
  parameter int DATA_W = 10,
  parameter int RES_W = 12,
  localparam int SEL_W = (N_SLICES > 1) ? $clog2(N_SLICES) : 1
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [N_SLICES*RES_W-1:0] slice_res_i,
  input  logic [SEL_W-1:0]          slice_sel_i,
  input  logic                      cal_busy_i,
  input  logic                      oe_n_i,
  inout  wire  [DATA_W-1:0]         dout_io,
  inout  wire                       ovr_io,
  output logic                      dvalid_o
);
  logic [RES_W-1:0]  picked;
  logic [DATA_W-1:0] code_c;
  logic              ovr_c;
  band_e             band_c;
  logic [DATA_W-1:0] code_q;
  logic              ovr_q;

  com_slice_sel #(.N_SLICES(N_SLICES), .RES_W(RES_W)) sel_i (
    .bus_i(slice_res_i), .sel_i(slice_sel_i), .res_o(picked)
  );

  com_range_clamp #(.DATA_W(DATA_W), .RES_W(RES_W)) clamp_i (
    .res_i(picked), .code_o(code_c), .ovr_o(ovr_c), .band_o(band_c)
  );

  com_out_stage #(.DATA_W(DATA_W)) stage_i (
    .clk(clk), .rst(rst), .code_i(code_c), .ovr_i(ovr_c),
    .busy_i(cal_busy_i), .code_q(code_q), .ovr_q(ovr_q), .valid_q(dvalid_o)
  );

  assign dout_io = oe_n_i ? {DATA_W{1'bz}} : code_q;
  assign ovr_io = oe_n_i ? 1'bz : ovr_q;

  a_r4_negative_gives_zero: assert property (@(posedge clk) disable iff (rst)
    picked[RES_W-1] |=> (code_q == '0 && !ovr_q));

  a_r2_inside_passes: assert property (@(posedge clk) disable iff (rst)
    (band_c == BAND_INSIDE) |=> (!ovr_q && code_q == $past(picked[DATA_W-1:0])));
endmodule

// File: tb/conv_out_mux_tb_top.sv
module conv_out_mux_tb_top;
  localparam int CLK_P = 10;
  localparam int NS = 4;
  localparam int DW = 4;
  localparam int RW = 6;
  localparam int SW = 2;
  localparam int FULL = (1 << DW) - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NS*RW-1:0] slices = '0;
  logic [SW-1:0] sel = '0;
  logic busy = 1'b1;
  logic oe_n = 1'b0;
  logic tb_drv = 1'b0;
  wire [DW-1:0] bus;
  wire ovr;
  logic dv;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  assign bus = tb_drv ? 4'b1010 : 4'bzzzz;
  assign ovr = tb_drv ? 1'b1 : 1'bz;

  always #(CLK_P/2) clk = ~clk;

  conv_out_mux #(.N_SLICES(NS), .DATA_W(DW), .RES_W(RW)) dut_i (
    .clk(clk), .rst(rst), .slice_res_i(slices), .slice_sel_i(sel),
    .cal_busy_i(busy), .oe_n_i(oe_n), .dout_io(bus), .ovr_io(ovr),
    .dvalid_o(dv)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_code(input int v);
    if (v < 0) return 0;
    if (v > FULL) return FULL;
    return v;
  endfunction

  initial begin
    // R8 reset state
    repeat (3) @(posedge clk);
    #1;
    chk(bus == 0, "R8 data", int'(bus), 0);
    chk(ovr == 1'b0, "R8 ovr", int'(ovr), 0);
    chk(dv == 1'b0, "R8 dv", int'(dv), 0);
    // R7 start-up: busy held high after reset
    @(negedge clk); rst = 1'b0;
    repeat (3) @(posedge clk);
    #1 chk(dv == 1'b0, "R7 busy start-up", int'(dv), 0);
    @(negedge clk); busy = 1'b0;
    #1 chk(dv == 1'b0, "R7 not before edge", int'(dv), 0);
    @(posedge clk); #1 chk(dv == 1'b1, "R7 valid after busy drops", int'(dv), 1);
    // R1..R5 exhaustive sweep, rotating select
    for (int v = -(1 << (RW-1)); v < (1 << (RW-1)); v++) begin
      for (int r = 0; r < NS; r++) begin
        int e;
        int pv;
        @(negedge clk);
        pv = int'(bus);
        for (int k = 0; k < NS; k++)
          slices[k*RW +: RW] = RW'(v + 13 + 7*k);
        slices[r*RW +: RW] = RW'(v);
        sel = SW'(r);
        #1 chk(int'(bus) == pv, "R5 no change between edges", int'(bus), pv);
        @(posedge clk); #1;
        e = exp_code(v);
        if (v < 0) chk(bus == 0 && ovr == 0, "R4 negative", int'(bus), 0);
        else if (v > FULL) chk(bus == DW'(FULL) && ovr == 1, "R3 overrange", int'(bus), FULL);
        else chk(int'(bus) == v && ovr == 0, "R2 in range", int'(bus), v);
        chk(int'(bus) == e, "R1 selected slice", int'(bus), e);
      end
    end
    // R6 release of the bus
    @(negedge clk);
    slices = '0; slices[2*RW +: RW] = RW'(5); sel = 2'd2;
    @(posedge clk);
    @(negedge clk); oe_n = 1'b1; tb_drv = 1'b1;
    #1 chk(bus == 4'b1010, "R6 data released", int'(bus), 10);
    chk(ovr == 1'b1, "R6 ovr released", int'(ovr), 1);
    chk(dv == 1'b1, "R7 dv not tristated", int'(dv), 1);
    @(negedge clk); tb_drv = 1'b0; oe_n = 1'b0;
    #1 chk(bus == 4'd5 && ovr == 1'b0, "R6 driven again", int'(bus), 5);
    // R7 busy mid-run, R8 reset mid-run
    @(negedge clk); busy = 1'b1;
    @(posedge clk); #1 chk(dv == 1'b0, "R7 busy mid-run", int'(dv), 0);
    @(negedge clk); busy = 1'b0; rst = 1'b1;
    @(posedge clk); #1 chk(bus == 0 && dv == 0, "R8 reset mid-run", int'(bus), 0);
    @(negedge clk); rst = 1'b0;
    @(posedge clk); #1 chk(bus == 4'd5 && dv == 1, "R1 resume after reset", int'(bus), 5);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule